// File: doc/BRIEF.md
# Lockable Device Control Register

This block is a small byte-addressed register group for a memory-expansion device's configuration structure. It holds a 16-bit control word, a sticky status field, a single lock bit and a set of memory range base registers, each range a low and a high 32-bit word. Software writes one byte at a time through a write port. Every writable byte passes through a fixed per-byte write mask, so bits outside the mask stay at zero.

The lock bit can be written only once after reset. Once it is set, the control word and every range base are frozen until the next reset. The status bits are set by hardware pulses and cleared by writing ones. They are sticky: they survive the ordinary reset and clear only on the power-on reset. Reads are combinational from a separate read address. The control word, the lock bit and the status field are also brought out directly for the logic that uses them.

Byte map (offsets in bytes): 0x00 is the control low byte and 0x01 the control high byte; 0x02 is status; 0x04 is lock. Range r has its low word at 0x08+8r..0x0B+8r and its high word at 0x0C+8r..0x0F+8r, little-endian. Every other offset reads 0 and ignores writes.

Top module: `devctl_lockable_regs`

## Requirements
- R1: A write to offset 0x00 stores only the bits of mask 0xFD, and a write to 0x01 stores only the bits of mask 0x4F. Bits outside the mask read 0. `ctrl_out` is {byte 0x01, byte 0x00}.
- R2: While `lock_out` is 1, writes to 0x00 and 0x01 leave the control word unchanged.
- R3: Only bit 0 of the lock byte at 0x04 is writable, and it reads back on `rd_data[0]`. The first write to 0x04 after reset loads `wr_data[0]`. Every later write to 0x04 is ignored, whether it carries 0 or 1.
- R4: Once set, the lock stays 1 until `rst_n` or `por_n` is asserted. Either reset clears it and re-arms the one-time write.
- R5: The status field is the low 4 bits at 0x02. Writing a 1 to one of these bits clears it, and writing 0 leaves it unchanged. Bits 7:4 read 0.
- R6: A 1 on `hw_stat_set[i]` sets status bit i at the next clock edge. If a set and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: Status keeps its value through `rst_n`, and hardware sets still act during `rst_n`. Status clears only on `por_n`.
- R8: All four bytes of each range high word are writable. In each range low word only byte 3 bits 7:4 (bits 31:28 of the word) are writable, and the other low-word bits read 0.
- R9: While `lock_out` is 1, writes to any range base byte leave it unchanged.
- R10: After either reset, the control word, the lock and all range bytes read 0, and unmapped offsets always read 0. Writes are ignored while either reset is asserted. Status is 0 after `por_n`.
- R11: `rd_data` follows `rd_addr` in the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears everything |
| rst_n | input | 1 | Ordinary reset, synchronous, active low; keeps status |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 8 | Read data byte (combinational) |
| hw_stat_set | input | STAT_W | Per-bit hardware set pulses for status |
| ctrl_out | output | 16 | Current control word |
| lock_out | output | 1 | Current lock bit |
| stat_out | output | STAT_W | Current status bits |

## Verification
Lock state that is wrong or has been lost shows at `lock_out` and at offset 0x04 within one cycle. A wrong "already written" flag stays hidden until the next write to 0x04, which then takes effect when it should be ignored, or the reverse. A lock that was dropped shows as a control or range byte that changes on the first write after the lock. Status that was lost across the ordinary reset, or a clear that beats a same-cycle set, shows at `stat_out` one edge after the event. A reference model compared on every cycle catches any of these by the next clock.

// File: rtl/devctl_pkg.sv
// devctl_pkg: byte offsets and write masks shared by the lockable
// device control register group and its checker.
package devctl_pkg;

    localparam int OFS_CTRL_LO  = 0;
    localparam int OFS_CTRL_HI  = 1;
    localparam int OFS_STAT     = 2;
    localparam int OFS_LOCK     = 4;
    localparam int RANGE_BASE   = 8;
    localparam int RANGE_STRIDE = 8;
    localparam int RANGE_BYTES  = 8;

    localparam logic [15:0] CTRL_WMASK = 16'h4FFD;

    // Writable bits of byte b within one range (low word bytes 0..3, high 4..7).
    function automatic logic [7:0] range_byte_mask(input int b);
        if (b >= 4)
            return 8'hFF;
        else if (b == 3)
            return 8'hF0;
        else
            return 8'h00;
    endfunction

endpackage

// File: rtl/devctl_mask_byte.sv
// devctl_mask_byte: one register byte that stores only the bits of MASK.
// Assumes the caller has already gated the write enable with the lock and
// the resets; bits outside MASK stay at their reset value of zero.
module devctl_mask_byte #(
    parameter logic [7:0] MASK = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wd,
    output logic [7:0] q
);

    // Masked byte update with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= (q & ~MASK) | (wd & MASK);
    end

endmodule

// File: rtl/devctl_lock_once.sv
// devctl_lock_once: lock bit that accepts exactly one write per reset.
// Assumes 'we' is already decoded for the lock offset and gated by reset.
module devctl_lock_once (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wbit,
    output logic locked
);

    logic used_q;

    // The first write loads the bit and arms the ignore flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= 1'b0;
            locked <= 1'b0;
        end else if (we && !used_q) begin
            used_q <= 1'b1;
            locked <= wbit;
        end
    end

endmodule

// File: rtl/devctl_sticky_stat.sv
// devctl_sticky_stat: write-one-to-clear status bits with hardware set.
// Cleared only by the power-on reset; a set beats a clear in the same cycle.
module devctl_sticky_stat #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] set,
    output logic [W-1:0] stat
);

    logic [W-1:0] clr_bits;

    // Bits cleared by the current write, if there is one.
    always_comb clr_bits = clr_en ? clr_mask : '0;

    // Clear first, then OR in the sets, so a set wins.
    always_ff @(posedge clk) begin
        if (!por_n)
            stat <= '0;
        else
            stat <= (stat & ~clr_bits) | set;
    end

endmodule

// File: rtl/devctl_lockable_regs.sv
// devctl_lockable_regs: byte-addressed control/status/lock/range-base
// register group. Control and range bytes are write-masked and frozen by a
// one-time lock; status is RW1C and sticky through rst_n. Assumes ADDR_W is
// wide enough to hold RANGE_BASE + N_RANGE*RANGE_STRIDE - 1.
module devctl_lockable_regs
    import devctl_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int N_RANGE = 2,
    parameter int STAT_W  = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic [STAT_W-1:0] hw_stat_set,
    output logic [15:0]       ctrl_out,
    output logic              lock_out,
    output logic [STAT_W-1:0] stat_out
);

    localparam int N_CTRL_BYTES = 2;

    logic rst_all_n;
    logic wr_ok;
    logic wr_open;
    logic [N_CTRL_BYTES-1:0][7:0] ctrl_q;
    logic [N_RANGE-1:0][RANGE_BYTES-1:0][7:0] range_q;

    // Combined reset for everything except status; writes need both released.
    always_comb rst_all_n = rst_n & por_n;
    always_comb wr_ok     = wr_en & rst_all_n;
    // Writes to lockable bytes pass only while unlocked.
    always_comb wr_open   = wr_ok & ~lock_out;

    // Control word bytes.
    for (genvar gi = 0; gi < N_CTRL_BYTES; gi++) begin : g_ctrl
        logic we_b;
        always_comb we_b = wr_open && (wr_addr == ADDR_W'(OFS_CTRL_LO + gi));
        devctl_mask_byte #(.MASK(CTRL_WMASK[8*gi +: 8])) u_byte (
            .clk  (clk),
            .rst_n(rst_all_n),
            .we   (we_b),
            .wd   (wr_data),
            .q    (ctrl_q[gi])
        );
    end

    always_comb ctrl_out = {ctrl_q[1], ctrl_q[0]};

    // Range base bytes; bytes with an empty mask are constant zero.
    for (genvar gr = 0; gr < N_RANGE; gr++) begin : g_rng
        for (genvar gb = 0; gb < RANGE_BYTES; gb++) begin : g_byte
            localparam logic [7:0] BMASK = range_byte_mask(gb);
            if (BMASK != 8'h00) begin : g_reg
                logic we_b;
                always_comb we_b = wr_open &&
                    (wr_addr == ADDR_W'(RANGE_BASE + gr*RANGE_STRIDE + gb));
                devctl_mask_byte #(.MASK(BMASK)) u_byte (
                    .clk  (clk),
                    .rst_n(rst_all_n),
                    .we   (we_b),
                    .wd   (wr_data),
                    .q    (range_q[gr][gb])
                );
            end else begin : g_zero
                assign range_q[gr][gb] = '0;
            end
        end
    end

    // One-time lock register.
    logic lock_we;
    always_comb lock_we = wr_ok && (wr_addr == ADDR_W'(OFS_LOCK));

    devctl_lock_once u_lock (
        .clk   (clk),
        .rst_n (rst_all_n),
        .we    (lock_we),
        .wbit  (wr_data[0]),
        .locked(lock_out)
    );

    // Sticky write-one-to-clear status.
    logic stat_we;
    always_comb stat_we = wr_ok && (wr_addr == ADDR_W'(OFS_STAT));

    devctl_sticky_stat #(.W(STAT_W)) u_stat (
        .clk     (clk),
        .por_n   (por_n),
        .clr_en  (stat_we),
        .clr_mask(wr_data[STAT_W-1:0]),
        .set     (hw_stat_set),
        .stat    (stat_out)
    );

    // Combinational byte read mux; unmapped offsets return zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_CTRL_LO))
            rd_data = ctrl_q[0];
        else if (rd_addr == ADDR_W'(OFS_CTRL_HI))
            rd_data = ctrl_q[1];
        else if (rd_addr == ADDR_W'(OFS_STAT))
            rd_data[STAT_W-1:0] = stat_out;
        else if (rd_addr == ADDR_W'(OFS_LOCK))
            rd_data[0] = lock_out;
        for (int r = 0; r < N_RANGE; r++) begin
            for (int b = 0; b < RANGE_BYTES; b++) begin
                if (rd_addr == ADDR_W'(RANGE_BASE + r*RANGE_STRIDE + b))
                    rd_data = range_q[r][b];
            end
        end
    end

endmodule

// File: rtl/devctl_lockable_regs_chk.sv
// devctl_lockable_regs_chk: temporal properties of the register group,
// observed at its ports and bound onto every instance of the top.
module devctl_lockable_regs_chk
    import devctl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int STAT_W = 4
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic [STAT_W-1:0] hw_stat_set,
    input logic [15:0]       ctrl_out,
    input logic              lock_out,
    input logic [STAT_W-1:0] stat_out
);

    // R4: lock stays set until a reset.
    p_lock_holds_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        lock_out |=> lock_out);

    // R2: control writes while locked leave the word unchanged.
    p_ctrl_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (lock_out && wr_en &&
         (wr_addr == ADDR_W'(OFS_CTRL_LO) || wr_addr == ADDR_W'(OFS_CTRL_HI)))
        |=> $stable(ctrl_out));

    // R6: a hardware set pulse sets its status bit at the next edge.
    p_hw_set_r6: assert property (@(posedge clk) disable iff (!por_n)
        (|hw_stat_set) |=> ((stat_out & $past(hw_stat_set)) == $past(hw_stat_set)));

    // R5: written ones clear status bits that are not being set.
    p_w1c_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (wr_en && wr_addr == ADDR_W'(OFS_STAT))
        |=> ((stat_out & $past(wr_data[STAT_W-1:0]) & ~$past(hw_stat_set)) == '0));

    // R7: status is retained across the ordinary reset.
    p_stat_keep_r7: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && hw_stat_set == '0) |=> $stable(stat_out));

    // R3: the lock offset reads back the lock bit alone.
    p_lock_read_r3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (rd_addr == ADDR_W'(OFS_LOCK)) |-> (rd_data == {7'b0, lock_out}));

endmodule

bind devctl_lockable_regs devctl_lockable_regs_chk #(
    .ADDR_W(ADDR_W),
    .STAT_W(STAT_W)
) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .hw_stat_set(hw_stat_set),
    .ctrl_out   (ctrl_out),
    .lock_out   (lock_out),
    .stat_out   (stat_out)
);

// File: tb/devctl_lockable_regs_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed checks plus a behavioural reference model
// compared on every falling edge.
module devctl_lockable_regs_test;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [3:0] hw_stat_set = '0;
    logic [15:0] ctrl_out;
    logic       lock_out;
    logic [3:0] stat_out;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    devctl_lockable_regs uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .hw_stat_set(hw_stat_set),
        .ctrl_out(ctrl_out), .lock_out(lock_out), .stat_out(stat_out)
    );

    // ---------------- reference model ----------------
    byte unsigned m_mem [32];
    bit           m_used;
    bit           m_lk;
    logic [3:0]   m_stat;

    function automatic logic [7:0] wmask(input int a);
        int off;
        if (a == 0) return 8'hFD;
        if (a == 1) return 8'h4F;
        if (a >= 8 && a < 24) begin
            off = (a - 8) % 8;
            if (off == 3) return 8'hF0;
            if (off >= 4) return 8'hFF;
        end
        return 8'h00;
    endfunction

    function automatic logic [7:0] m_read(input int a);
        if (a == 2) return {4'b0, m_stat};
        if (a == 4) return {7'b0, m_lk};
        return m_mem[a];
    endfunction

    always @(posedge clk) begin
        logic [3:0] clr;
        clr = (por_n && rst_n && wr_en && wr_addr == 5'd2) ? wr_data[3:0] : 4'h0;
        if (!por_n) m_stat = 4'h0;
        else        m_stat = (m_stat & ~clr) | hw_stat_set;
        if (!por_n || !rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 8'h00;
            m_used = 0;
            m_lk = 0;
        end else if (wr_en) begin
            if (wr_addr == 5'd4) begin
                if (!m_used) begin
                    m_used = 1;
                    m_lk = wr_data[0];
                end
            end else if (wr_addr != 5'd2 && !m_lk) begin
                m_mem[wr_addr] = wr_data & wmask(int'(wr_addr));
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1 model ctrl_out", ctrl_out, {m_mem[1], m_mem[0]});
            chk("R3 model lock_out", {15'b0, lock_out}, {15'b0, m_lk});
            chk("R7 model stat_out", {12'b0, stat_out}, {12'b0, m_stat});
            chk("R10 model rd_data", {8'b0, rd_data}, {8'b0, m_read(int'(rd_addr))});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input bit we, input int a, input logic [7:0] d, input logic [3:0] hw);
        @(negedge clk); #1;
        wr_en = we; wr_addr = 5'(a); wr_data = d; hw_stat_set = hw;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        cyc(1'b1, a, d, 4'h0);
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [7:0] exp);
        @(negedge clk); #1;
        wr_en = 0; hw_stat_set = '0;
        rd_addr = 5'(a);
        #0.5;
        chk(tag, {8'b0, rd_data}, {8'b0, exp});
    endtask

    task automatic pulse_rst(input bit por);
        @(negedge clk); #1;
        wr_en = 0; hw_stat_set = '0;
        if (por) por_n = 0; else rst_n = 0;
        @(negedge clk); #1;
        por_n = 1; rst_n = 1;
    endtask

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        #1; por_n = 1; rst_n = 1;
        started = 1;

        // R10: everything reads zero after reset.
        for (int a = 0; a < 32; a++) rd_chk("R10 reset read", a, 8'h00);
        chk("R10 reset ctrl_out", ctrl_out, 16'h0000);

        // R1: control write masks.
        wr(0, 8'hFF); wr(1, 8'hFF);
        rd_chk("R1 ctrl lo mask", 0, 8'hFD);
        rd_chk("R1 ctrl hi mask", 1, 8'h4F);
        chk("R1 ctrl_out", ctrl_out, 16'h4FFD);

        // R6 and R5: hardware set, W1C, write of zero.
        cyc(1'b0, 0, 8'h00, 4'h5);
        rd_chk("R6 hw set", 2, 8'h05);
        wr(2, 8'hF4);
        rd_chk("R5 w1c", 2, 8'h01);
        wr(2, 8'h00);
        rd_chk("R5 write zero keeps", 2, 8'h01);
        cyc(1'b1, 2, 8'h01, 4'h1);
        rd_chk("R6 set beats clear", 2, 8'h01);

        // R8: range masks.
        for (int a = 8; a < 12; a++) wr(a, 8'hFF);
        for (int a = 12; a < 16; a++) wr(a, 8'hA5);
        wr(19, 8'h3C);
        rd_chk("R8 range lo byte0", 8, 8'h00);
        rd_chk("R8 range lo byte3", 11, 8'hF0);
        rd_chk("R8 range hi byte0", 12, 8'hA5);
        rd_chk("R8 range hi byte3", 15, 8'hA5);
        rd_chk("R8 range1 lo byte3", 19, 8'h30);

        // R3: only bit0, first write wins even when it writes zero.
        wr(4, 8'hFE);
        rd_chk("R3 lock bit0 only", 4, 8'h00);
        wr(4, 8'h01);
        rd_chk("R3 second write ignored", 4, 8'h00);
        wr(0, 8'h10);
        rd_chk("R2 unlocked write works", 0, 8'h10);

        // R7 and R4: ordinary reset keeps status, clears lock state.
        pulse_rst(1'b0);
        rd_chk("R7 status kept", 2, 8'h01);
        rd_chk("R10 ctrl cleared", 0, 8'h00);
        rd_chk("R10 range cleared", 12, 8'h00);

        // Re-armed lock; R2 and R9 freeze.
        wr(0, 8'h11);
        wr(13, 8'h22);
        wr(4, 8'h01);
        rd_chk("R4 lock re-armed", 4, 8'h01);
        chk("R4 lock_out", {15'b0, lock_out}, 16'h0001);
        wr(0, 8'hFF); wr(1, 8'hFF);
        rd_chk("R2 ctrl frozen", 0, 8'h11);
        chk("R2 ctrl_out frozen", ctrl_out, 16'h0011);
        wr(13, 8'h77); wr(11, 8'hFF);
        rd_chk("R9 range hi frozen", 13, 8'h22);
        rd_chk("R9 range lo frozen", 11, 8'h00);
        wr(4, 8'h00);
        rd_chk("R4 zero write keeps lock", 4, 8'h01);
        wr(2, 8'h01);
        rd_chk("R5 status clears while locked", 2, 8'h00);

        // R11: read follows address with no clock edge.
        @(negedge clk); #1;
        rd_addr = 5'd0; #0.3;
        chk("R11 comb read ctrl", {8'b0, rd_data}, 16'h0011);
        rd_addr = 5'd4; #0.3;
        chk("R11 comb read lock", {8'b0, rd_data}, 16'h0001);

        // R4 and R7: resets.
        cyc(1'b0, 0, 8'h00, 4'hA);
        pulse_rst(1'b0);
        rd_chk("R4 reset clears lock", 4, 8'h00);
        rd_chk("R7 status survives rst", 2, 8'h0A);
        pulse_rst(1'b1);
        rd_chk("R7 por clears status", 2, 8'h00);

        // Random traffic, model-compared every cycle.
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk); #1;
            wr_en = ($urandom % 3) != 0;
            wr_addr = 5'($urandom % 32);
            if (($urandom % 4) == 0) wr_addr = 5'd4;
            wr_data = 8'($urandom);
            hw_stat_set = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
            rd_addr = 5'($urandom % 32);
            rst_n = ($urandom % 64) != 0;
            por_n = ($urandom % 256) != 0;
        end
        @(negedge clk); #1;
        por_n = 1; rst_n = 1; wr_en = 0; hw_stat_set = '0;
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule